// File: doc/BRIEF.md
# Translation Unit Control and Fault Register File

This block is the software-facing register file of an address translation unit that sits in front of a media engine. It takes single-cycle 32-bit word reads and writes on a plain register bus. From those registers it drives the walker's controls: the translation enable, the base address of the root pointer table, the out-of-bound check enable, and a one-cycle TLB flush strobe.

The block also collects fault reports from the walker. Each report sets cause bits in a sticky status register. The first fault after a clean status latches its faulting address. An interrupt line is raised while any cause is pending and exceptions are enabled. While translation is off, the block hands the client's address through unchanged and records no faults. When translation is on, it forwards the walker's translated address instead.

A driver brings translation up by writing four registers in turn: the root base, then the configuration, then the exception enable, then the control enable. To flush the TLB, software sets the flush bit and then writes zero to it. The word at 0x380 is asymmetric. A write to it sets the exception enable, and a read from it returns the latched fault address.

Top module: `tu_ctrl_regs`

## Requirements
- R1: Bit 0 of the control word at offset 0x388 is the translation enable and drives `xlat_en_o`. A write with bit 0 clear disables translation. A read returns the bit in position 0 and zeros elsewhere.
- R2: The word at offset 0x38C holds a 32-bit root table base. All 32 bits are stored, driven on `root_base_o`, and read back unchanged.
- R3: In the configuration word at offset 0x1AC, only bit 28 is kept. That bit is the out-of-bound check enable and drives `oob_chk_en_o`. A read returns only that bit, and all other bits read as 0.
- R4: Bit 4 of the word at offset 0x184 is the flush request, and it reads back in position 4. `flush_o` goes high for exactly one cycle, in the cycle after a write that takes the bit from 0 to 1. A write that leaves the bit at 1 gives no pulse.
- R5: While translation is disabled, `out_addr_o` equals `cli_addr_i`, and walker fault reports are ignored. While it is enabled, `out_addr_o` equals `wlk_addr_i`.
- R6: While translation is enabled, a fault report ORs `flt_cause_i` into the 3-bit status held in bits 2:0 of offset 0x384. The report's address is latched only if the status was zero beforehand. Otherwise the latched address is held. A read of offset 0x380 returns the latched address.
- R7: A write to offset 0x384 ANDs the status with bits 2:0 of the write data, so writing 0 clears every cause. A fault reported in the same cycle is applied after the clear and survives it.
- R8: A write to offset 0x380 sets the exception enable from bit 0. `irq_o` is high exactly when the exception enable is set and at least one status bit is set.
- R9: Offsets other than the six listed read as 0, and writes to them change no register or output.
- R10: `bus_rdata_o` takes the read value at the clock edge that samples a read strobe. It holds that value through all later cycles without a read, including write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W | Byte offset of the word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| cli_addr_i | input | XA_W | Untranslated client address |
| wlk_addr_i | input | XA_W | Translated address from the walker |
| out_addr_o | output | XA_W | Address presented downstream |
| flt_valid_i | input | 1 | Walker fault report strobe |
| flt_cause_i | input | NCAUSE | Fault cause bits |
| flt_addr_i | input | 32 | Faulting address |
| xlat_en_o | output | 1 | Translation enable |
| root_base_o | output | 32 | Root pointer table base |
| oob_chk_en_o | output | 1 | Out-of-bound check enable |
| flush_o | output | 1 | One-cycle TLB flush strobe |
| irq_o | output | 1 | Fault interrupt |

## Verification
Register writes, status updates from fault reports, and the exception gating all take effect at the clock edge that samples the strobe. The outputs that depend on them change in the cycle right after that edge. The bench drives every strobe on a falling edge for one cycle and samples at the next falling edge. Read data follows the same one-edge rule, so each read task returns the value seen half a cycle after the capturing edge.

The flush pulse is checked at that same falling edge and again one cycle later, to prove it lasts exactly one cycle. The address path is combinational, so it is checked in the same half-cycle in which the enable changes. Reset release passes through a two-stage synchronizer, so the bench waits several cycles before its first access.

// File: rtl/tu_regs_pkg.sv
package tu_regs_pkg;

  // Word offsets; software relies on these positions.
  localparam logic [11:0] OFS_FLUSH  = 12'h184;
  localparam logic [11:0] OFS_CFG    = 12'h1AC;
  localparam logic [11:0] OFS_FAULT  = 12'h380;
  localparam logic [11:0] OFS_STATUS = 12'h384;
  localparam logic [11:0] OFS_CTRL   = 12'h388;
  localparam logic [11:0] OFS_ROOT   = 12'h38C;

  localparam int unsigned FLUSH_BIT = 4;
  localparam int unsigned OOB_BIT   = 28;
  localparam int unsigned EN_BIT    = 0;
  localparam int unsigned WORD_W    = 32;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_FLUSH,
    SEL_CFG,
    SEL_FAULT,
    SEL_STATUS,
    SEL_CTRL,
    SEL_ROOT
  } reg_sel_e;

endpackage

// File: rtl/tu_rst_sync.sv
module tu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/tu_reg_decode.sv
module tu_reg_decode
  import tu_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  localparam logic [ADDR_W-1:0] A_FLUSH  = ADDR_W'(OFS_FLUSH);
  localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_FAULT  = ADDR_W'(OFS_FAULT);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_ROOT   = ADDR_W'(OFS_ROOT);

  always_comb begin
    sel_o = SEL_NONE;
    if      (addr_i == A_FLUSH)  sel_o = SEL_FLUSH;
    else if (addr_i == A_CFG)    sel_o = SEL_CFG;
    else if (addr_i == A_FAULT)  sel_o = SEL_FAULT;
    else if (addr_i == A_STATUS) sel_o = SEL_STATUS;
    else if (addr_i == A_CTRL)   sel_o = SEL_CTRL;
    else if (addr_i == A_ROOT)   sel_o = SEL_ROOT;
  end
endmodule

// File: rtl/tu_flush_pulse.sv
module tu_flush_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wbit_i,
  output logic bit_o,
  output logic pulse_o
);
  logic bit_q, bit_n;
  logic pulse_q, pulse_n;

  always_comb begin
    bit_n   = wr_en_i ? wbit_i : bit_q;
    pulse_n = wr_en_i & wbit_i & ~bit_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      bit_q   <= bit_n;
      pulse_q <= pulse_n;
    end
  end

  assign bit_o   = bit_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/tu_fault_capture.sv
module tu_fault_capture #(
  parameter int unsigned NCAUSE = 3,
  parameter int unsigned FA_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_en_i,
  input  logic              flt_valid_i,
  input  logic [NCAUSE-1:0] flt_cause_i,
  input  logic [FA_W-1:0]   flt_addr_i,
  input  logic              clr_we_i,
  input  logic [NCAUSE-1:0] clr_mask_i,
  output logic [NCAUSE-1:0] sts_o,
  output logic [FA_W-1:0]   faddr_o
);
  logic [NCAUSE-1:0] sts_q, sts_n, kept, incoming;
  logic [FA_W-1:0]   faddr_q;
  logic              addr_ld;

  always_comb begin
    kept     = clr_we_i ? (sts_q & clr_mask_i) : sts_q;
    incoming = (capture_en_i && flt_valid_i) ? flt_cause_i : '0;
    sts_n    = kept | incoming;
    addr_ld  = (kept == '0) && (incoming != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= sts_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      faddr_q <= '0;
    else if (addr_ld) faddr_q <= flt_addr_i;
  end

  assign sts_o   = sts_q;
  assign faddr_o = faddr_q;
endmodule

// File: rtl/tu_ctrl_regs.sv
module tu_ctrl_regs
  import tu_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned XA_W   = 32,
  parameter int unsigned NCAUSE = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [XA_W-1:0]   cli_addr_i,
  input  logic [XA_W-1:0]   wlk_addr_i,
  output logic [XA_W-1:0]   out_addr_o,
  input  logic              flt_valid_i,
  input  logic [NCAUSE-1:0] flt_cause_i,
  input  logic [31:0]       flt_addr_i,
  output logic              xlat_en_o,
  output logic [31:0]       root_base_o,
  output logic              oob_chk_en_o,
  output logic              flush_o,
  output logic              irq_o
);
  localparam int unsigned PAD_W = WORD_W - NCAUSE;

  logic     rst_sn;
  reg_sel_e sel;
  logic     wr_stb, rd_stb;
  logic     flush_bit;
  logic [NCAUSE-1:0] sts_q;
  logic [31:0]       faddr_q;

  logic        en_q, en_n;
  logic        exc_q, exc_n;
  logic        oob_q, oob_n;
  logic [31:0] root_q, root_n;
  logic [31:0] rdata_q, rdata_n;

  tu_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sn)
  );

  tu_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (bus_addr_i),
    .sel_o  (sel)
  );

  assign wr_stb = bus_sel_i &  bus_wr_i;
  assign rd_stb = bus_sel_i & ~bus_wr_i;

  tu_flush_pulse u_flush (
    .clk_i   (clk_i),
    .rst_ni  (rst_sn),
    .wr_en_i (wr_stb && (sel == SEL_FLUSH)),
    .wbit_i  (bus_wdata_i[FLUSH_BIT]),
    .bit_o   (flush_bit),
    .pulse_o (flush_o)
  );

  tu_fault_capture #(.NCAUSE(NCAUSE), .FA_W(32)) u_flt (
    .clk_i        (clk_i),
    .rst_ni       (rst_sn),
    .capture_en_i (en_q),
    .flt_valid_i  (flt_valid_i),
    .flt_cause_i  (flt_cause_i),
    .flt_addr_i   (flt_addr_i),
    .clr_we_i     (wr_stb && (sel == SEL_STATUS)),
    .clr_mask_i   (bus_wdata_i[NCAUSE-1:0]),
    .sts_o        (sts_q),
    .faddr_o      (faddr_q)
  );

  // Next-state for the plain control registers
  always_comb begin
    en_n   = en_q;
    exc_n  = exc_q;
    oob_n  = oob_q;
    root_n = root_q;
    if (wr_stb) begin
      unique case (sel)
        SEL_CTRL:  en_n   = bus_wdata_i[EN_BIT];
        SEL_FAULT: exc_n  = bus_wdata_i[EN_BIT];
        SEL_CFG:   oob_n  = bus_wdata_i[OOB_BIT];
        SEL_ROOT:  root_n = bus_wdata_i;
        default:   ;
      endcase
    end
  end

  // Read mux
  always_comb begin
    rdata_n = '0;
    unique case (sel)
      SEL_CTRL:   rdata_n[EN_BIT]    = en_q;
      SEL_ROOT:   rdata_n            = root_q;
      SEL_CFG:    rdata_n[OOB_BIT]   = oob_q;
      SEL_FLUSH:  rdata_n[FLUSH_BIT] = flush_bit;
      SEL_FAULT:  rdata_n            = faddr_q;
      SEL_STATUS: rdata_n            = {{PAD_W{1'b0}}, sts_q};
      default:    rdata_n            = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_sn) begin
    if (!rst_sn) begin
      en_q   <= 1'b0;
      exc_q  <= 1'b0;
      oob_q  <= 1'b0;
      root_q <= '0;
    end else begin
      en_q   <= en_n;
      exc_q  <= exc_n;
      oob_q  <= oob_n;
      root_q <= root_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sn) begin
    if (!rst_sn)     rdata_q <= '0;
    else if (rd_stb) rdata_q <= rdata_n;
  end

  assign bus_rdata_o  = rdata_q;
  assign xlat_en_o    = en_q;
  assign root_base_o  = root_q;
  assign oob_chk_en_o = oob_q;
  assign irq_o        = exc_q & (|sts_q);
  assign out_addr_o   = en_q ? wlk_addr_i : cli_addr_i;
endmodule

// File: rtl/tu_ctrl_regs_chk.sv
module tu_ctrl_regs_chk
  import tu_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NCAUSE = 3
) (
  input logic              clk_i,
  input logic              rst_sn,
  input logic              bus_sel_i,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic              xlat_en_o,
  input logic [31:0]       root_base_o,
  input logic              flush_o,
  input logic              irq_o,
  input logic [NCAUSE-1:0] sts_q,
  input logic [31:0]       faddr_q
);
  logic wr_ctrl, wr_root, wr_sts;
  assign wr_ctrl = bus_sel_i && bus_wr_i && (bus_addr_i == ADDR_W'(OFS_CTRL));
  assign wr_root = bus_sel_i && bus_wr_i && (bus_addr_i == ADDR_W'(OFS_ROOT));
  assign wr_sts  = bus_sel_i && bus_wr_i && (bus_addr_i == ADDR_W'(OFS_STATUS));

  a_r1_ctrl_enable: assert property (@(posedge clk_i) disable iff (!rst_sn)
    wr_ctrl |=> (xlat_en_o == $past(bus_wdata_i[0])));

  a_r2_root_load: assert property (@(posedge clk_i) disable iff (!rst_sn)
    wr_root |=> (root_base_o == $past(bus_wdata_i)));

  a_r4_flush_single: assert property (@(posedge clk_i) disable iff (!rst_sn)
    flush_o |=> !flush_o);

  a_r5_no_record_off: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (!xlat_en_o && !wr_sts) |=> $stable(sts_q));

  a_r6_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_sn)
    ((sts_q != '0) && !wr_sts) |=> $stable(faddr_q));

  a_r8_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_sn)
    irq_o |-> (sts_q != '0));
endmodule

bind tu_ctrl_regs tu_ctrl_regs_chk #(.ADDR_W(ADDR_W), .NCAUSE(NCAUSE)) u_chk (
  .clk_i       (clk_i),
  .rst_sn      (rst_sn),
  .bus_sel_i   (bus_sel_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .xlat_en_o   (xlat_en_o),
  .root_base_o (root_base_o),
  .flush_o     (flush_o),
  .irq_o       (irq_o),
  .sts_q       (sts_q),
  .faddr_q     (faddr_q)
);

// File: tb/tu_ctrl_regs_tb.sv
`timescale 1ns/1ps
module tu_ctrl_regs_tb;
  localparam logic [11:0] A_FLUSH = 12'h184, A_CFG = 12'h1AC, A_FAULT = 12'h380,
                          A_STS = 12'h384, A_CTRL = 12'h388, A_ROOT = 12'h38C,
                          A_BAD = 12'h100;
  localparam logic [31:0] CLI = 32'h1234_5678, WLK = 32'h0ABC_DEF0;

  logic clk = 1'b0;
  logic rst_n;
  logic sel, wr;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;
  logic [31:0] cli, wlk, oaddr;
  logic fv;
  logic [2:0] fc;
  logic [31:0] fa;
  logic xen, oob, fl, irq;
  logic [31:0] root;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tu_ctrl_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cli_addr_i(cli), .wlk_addr_i(wlk),
    .out_addr_o(oaddr), .flt_valid_i(fv), .flt_cause_i(fc), .flt_addr_i(fa),
    .xlat_en_o(xen), .root_base_o(root), .oob_chk_en_o(oob), .flush_o(fl), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    @(negedge clk); sel = 0; d = rdata;
  endtask

  task automatic fault(input logic [2:0] c, input logic [31:0] a);
    @(negedge clk); fv = 1; fc = c; fa = a;
    @(negedge clk); fv = 0; fc = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 reset en", {31'b0, xen}, 0);
    chk("R4 reset flush", {31'b0, fl}, 0);
    chk("R8 reset irq", {31'b0, irq}, 0);
    chk("R5 reset pass", oaddr, CLI);
    bus_rd(A_STS, d);  chk("R6 reset status", d, 0);
    bus_rd(A_ROOT, d); chk("R2 reset root", d, 0);
  endtask

  task automatic t_r1_ctrl();
    logic [31:0] d;
    bus_wr(A_CTRL, 32'hFFFF_FFFF);
    chk("R1 enable", {31'b0, xen}, 1);
    bus_rd(A_CTRL, d); chk("R1 readback", d, 1);
    bus_wr(A_CTRL, 0);
    chk("R1 disable", {31'b0, xen}, 0);
  endtask

  task automatic t_r2_root();
    logic [31:0] d;
    bus_wr(A_ROOT, 32'hA5A5_1C3F);
    chk("R2 output", root, 32'hA5A5_1C3F);
    bus_rd(A_ROOT, d); chk("R2 readback", d, 32'hA5A5_1C3F);
  endtask

  task automatic t_r3_cfg();
    logic [31:0] d;
    bus_wr(A_CFG, 32'hFFFF_FFFF);
    chk("R3 oob out", {31'b0, oob}, 1);
    bus_rd(A_CFG, d); chk("R3 readback", d, 32'h1000_0000);
    bus_wr(A_CFG, 32'hEFFF_FFFF);
    chk("R3 oob cleared", {31'b0, oob}, 0);
  endtask

  task automatic t_r4_flush();
    logic [31:0] d;
    bus_wr(A_FLUSH, 32'h10);
    chk("R4 pulse", {31'b0, fl}, 1);
    @(negedge clk); chk("R4 pulse width", {31'b0, fl}, 0);
    bus_rd(A_FLUSH, d); chk("R4 readback", d, 32'h10);
    bus_wr(A_FLUSH, 32'h10);
    chk("R4 no pulse while set", {31'b0, fl}, 0);
    bus_wr(A_FLUSH, 0);
    chk("R4 clear no pulse", {31'b0, fl}, 0);
    bus_wr(A_FLUSH, 32'h10);
    chk("R4 second pulse", {31'b0, fl}, 1);
    bus_wr(A_FLUSH, 0);
  endtask

  task automatic t_r5_pass();
    logic [31:0] d;
    chk("R5 disabled pass", oaddr, CLI);
    bus_wr(A_FAULT, 1);
    fault(3'b111, 32'hDEAD_0000);
    bus_rd(A_STS, d); chk("R5 fault ignored off", d, 0);
    chk("R5 no irq off", {31'b0, irq}, 0);
    bus_wr(A_CTRL, 1);
    chk("R5 enabled xlat", oaddr, WLK);
  endtask

  task automatic t_r6_capture();
    logic [31:0] d;
    fault(3'b010, 32'h0000_4A00);
    chk("R8 irq set", {31'b0, irq}, 1);
    bus_rd(A_STS, d);   chk("R6 status", d, 2);
    bus_rd(A_FAULT, d); chk("R6 addr", d, 32'h0000_4A00);
    fault(3'b001, 32'h0000_7700);
    bus_rd(A_STS, d);   chk("R6 status or", d, 3);
    bus_rd(A_FAULT, d); chk("R6 addr held", d, 32'h0000_4A00);
  endtask

  task automatic t_r7_clear();
    logic [31:0] d;
    bus_wr(A_STS, 32'h1);
    bus_rd(A_STS, d); chk("R7 partial clear", d, 1);
    bus_wr(A_STS, 0);
    bus_rd(A_STS, d); chk("R7 clear all", d, 0);
    chk("R7 irq cleared", {31'b0, irq}, 0);
    fault(3'b100, 32'h0000_9100);
    bus_rd(A_FAULT, d); chk("R7 new addr after clear", d, 32'h0000_9100);
    // clear and fault in same cycle
    @(negedge clk); sel = 1; wr = 1; addr = A_STS; wdata = 0; fv = 1; fc = 3'b001; fa = 32'h0000_5500;
    @(negedge clk); sel = 0; wr = 0; fv = 0; fc = 0;
    bus_rd(A_STS, d);   chk("R7 fault wins over clear", d, 1);
    bus_rd(A_FAULT, d); chk("R7 addr on same-cycle", d, 32'h0000_5500);
  endtask

  task automatic t_r8_gate();
    bus_wr(A_FAULT, 0);
    chk("R8 irq gated off", {31'b0, irq}, 0);
    bus_wr(A_FAULT, 1);
    chk("R8 irq gated on", {31'b0, irq}, 1);
    bus_wr(A_STS, 0);
  endtask

  task automatic t_r9_unmapped();
    logic [31:0] d;
    bus_wr(A_BAD, 32'hFFFF_FFFF);
    bus_rd(A_BAD, d); chk("R9 unmapped read", d, 0);
    chk("R9 root intact", root, 32'hA5A5_1C3F);
    chk("R9 en intact", {31'b0, xen}, 1);
    chk("R9 no flush", {31'b0, fl}, 0);
    bus_rd(A_CTRL, d); chk("R9 ctrl intact", d, 1);
  endtask

  task automatic t_r10_hold();
    logic [31:0] d;
    bus_rd(A_ROOT, d);
    bus_wr(A_CTRL, 1);
    chk("R10 hold on write", rdata, 32'hA5A5_1C3F);
    repeat (3) @(negedge clk);
    chk("R10 hold idle", rdata, 32'hA5A5_1C3F);
  endtask

  initial begin
    rst_n = 0; sel = 0; wr = 0; addr = 0; wdata = 0;
    cli = CLI; wlk = WLK; fv = 0; fc = 0; fa = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_r1_ctrl();
    t_r2_root();
    t_r3_cfg();
    t_r4_flush();
    t_r5_pass();
    t_r6_capture();
    t_r7_clear();
    t_r8_gate();
    t_r9_unmapped();
    t_r10_hold();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule